// File: doc/BRIEF.md
# DTMF Dual Tone Generator

This block produces the two-frequency signalling tones used for telephone keypad dialing. It runs directly from a 3.579545 MHz reference clock. Each tone is made by a programmable divider that walks through a 16-step sine table, so every frequency is the clock divided by sixteen times an integer reload. This puts the row tones at about 699, 766, 848 and 948 Hz and the column tones at about 1216, 1332 and 1472 Hz, each within 0.8 % of its nominal value. The output is an unsigned sample word for an external DAC. It is the row sample plus the column sample, and the column table is about 2 dB louder than the row table to give pre-emphasis.

A dialing sequencer hands over one decoded key at a time on a valid/ready request channel. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While `req_ready` is low the sequencer must hold its request; holding it has no effect until ready returns. Once a key is taken, `busy` stays high through the tone and through the silent gap that follows it. The tone lasts as long as `key_held` stays high, and never less than the minimum tone time. The gap that follows always lasts exactly the minimum gap time. A mix selector picks dual-tone output, or a single row or column tone for test. When tone mode is off (pulse dialing), the output stays at zero.

Top module: `dtmf_tone_gen`

## Requirements
- R1: `req_ready` equals `tone_en` and not `busy`. A request is taken only on an edge where `req_valid` and `req_ready` are both high. A valid code that is taken raises `busy` from the next cycle. A request held while `busy` is high starts nothing.
- R2: The digit codes map to keypad positions as follows. Codes 1 to 9 fill rows 0 to 2 from left to right, three per row. Code 10 is row 3, column 0. Code 0 is row 3, column 1. Code 11 is row 3, column 2.
- R3: Each tone steps its table once every reload cycles, where reload = round(CLK_HZ / (16 × f)). For rows 0 to 3, f is 699, 766, 848 and 948 Hz, giving reloads 320, 292, 264 and 236. For columns 0 to 2, f is 1216, 1332 and 1472 Hz, giving reloads 184, 168 and 152. Both tables start at step 0 when a tone begins.
- R4: Row table entry k is round(64 + 60·sin(2πk/16)). Column table entry k is round(80 + 76·sin(2πk/16)). During a tone, the sample is the sum of the enabled entries.
- R5: `req_mode` is latched when a request is taken. Values 0 and 3 give dual tone, 1 gives the row tone only and 2 gives the column tone only. A tone that is switched off contributes zero.
- R6: Let K be the number of edges after the taking edge at which `key_held` is sampled high. The tone then lasts max(MIN_TONE_CYC, K+1) cycles.
- R7: After the tone, `tone_sample` is zero and `busy` stays high for exactly MIN_GAP_CYC cycles. `busy` is high for the tone length plus MIN_GAP_CYC in total.
- R8: While `tone_en` is low, `req_ready` is low and `tone_sample` is zero from the next cycle on. Dropping `tone_en` during a tone aborts it, and `busy` falls on the next cycle.
- R9: Codes 12 to 15 are taken by the handshake but start no tone. `busy` stays low.
- R10: During and after reset, `busy` is low and `tone_sample` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.579545 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_en | input | 1 | Tone mode enable; low selects pulse dialing and silences the output |
| key_held | input | 1 | High while the key of the current tone is still pressed |
| req_valid | input | 1 | A digit request is offered |
| req_ready | output | 1 | The generator can take a request |
| req_digit | input | 4 | Digit code (see R2) |
| req_mode | input | 2 | Mix select: dual, row only or column only |
| busy | output | 1 | Tone or post-tone gap in progress |
| tone_sample | output | 9 | Unsigned sample word for the DAC |

## Verification
`busy` is due one cycle after the edge that takes the request. The first tone sample appears one cycle after that, because the sample register follows the tone state. After the last tone cycle, the sample falls to zero one cycle later, and `busy` falls after the gap. The bench drives inputs on falling edges and reads outputs on falling edges. It walks a cycle index m from the taking edge and compares every cycle against a model. In that model, sample m is the table value at step floor((m−1)/reload), so the reload of each tone and the lengths of tone and gap are all checked cycle by cycle. Abort, invalid-code and reset results are read on the first falling edge after the edge that should produce them.

// File: rtl/dtmf_gen_pkg.sv
package dtmf_gen_pkg;

  localparam int TAB_W    = 8;
  localparam int SAMPLE_W = TAB_W + 1;
  localparam int PHASE_W  = 4;
  localparam int DIV_W    = 12;
  localparam int N_ROWS   = 4;
  localparam int N_COLS   = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TONE = 2'd1,
    ST_GAP  = 2'd2
  } tone_state_e;

  typedef enum logic [1:0] {
    MIX_DUAL = 2'd0,
    MIX_ROW  = 2'd1,
    MIX_COL  = 2'd2,
    MIX_ALSO = 2'd3
  } mix_e;

  typedef struct packed {
    logic       ok;
    logic [1:0] row;
    logic [1:0] col;
  } key_pos_t;

  // Divider reload that lands the 16-step sine cycle nearest the target.
  function automatic int reload_for(int clk_hz, int tone_hz);
    return (clk_hz + 8 * tone_hz) / (16 * tone_hz);
  endfunction

  function automatic int row_hz(int idx);
    case (idx)
      0:       return 699;
      1:       return 766;
      2:       return 848;
      default: return 948;
    endcase
  endfunction

  function automatic int col_hz(int idx);
    case (idx)
      0:       return 1216;
      1:       return 1332;
      default: return 1472;
    endcase
  endfunction

  function automatic key_pos_t decode_key(logic [3:0] code);
    key_pos_t p;
    p = '{ok: 1'b1, row: 2'd0, col: 2'd0};
    case (code)
      4'd1:  begin p.row = 2'd0; p.col = 2'd0; end
      4'd2:  begin p.row = 2'd0; p.col = 2'd1; end
      4'd3:  begin p.row = 2'd0; p.col = 2'd2; end
      4'd4:  begin p.row = 2'd1; p.col = 2'd0; end
      4'd5:  begin p.row = 2'd1; p.col = 2'd1; end
      4'd6:  begin p.row = 2'd1; p.col = 2'd2; end
      4'd7:  begin p.row = 2'd2; p.col = 2'd0; end
      4'd8:  begin p.row = 2'd2; p.col = 2'd1; end
      4'd9:  begin p.row = 2'd2; p.col = 2'd2; end
      4'd10: begin p.row = 2'd3; p.col = 2'd0; end
      4'd0:  begin p.row = 2'd3; p.col = 2'd1; end
      4'd11: begin p.row = 2'd3; p.col = 2'd2; end
      default: p.ok = 1'b0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/dtmf_phase_div.sv
module dtmf_phase_div
  import dtmf_gen_pkg::*;
#(
  parameter int RL_W = DIV_W,
  parameter int PH_W = PHASE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            run,
  input  logic [RL_W-1:0] reload,
  output logic [PH_W-1:0] phase
);

  logic [RL_W-1:0] rl_q;
  logic [RL_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rl_q  <= '0;
      cnt_q <= '0;
      phase <= '0;
    end else if (start) begin
      rl_q  <= reload;
      cnt_q <= reload - RL_W'(1);
      phase <= '0;
    end else if (run) begin
      if (cnt_q == '0) begin
        cnt_q <= rl_q - RL_W'(1);
        phase <= phase + PH_W'(1);
      end else begin
        cnt_q <= cnt_q - RL_W'(1);
      end
    end
  end

  // R3: the table index moves only when the divider wraps
  p_hold_between_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && cnt_q != '0) |=> $stable(phase));

  p_step_on_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && cnt_q == '0) |=> phase == $past(phase) + PH_W'(1));

  p_restart_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> phase == '0);

endmodule

// File: rtl/dtmf_sine_rom.sv
module dtmf_sine_rom
  import dtmf_gen_pkg::*;
#(
  parameter bit LOUD = 1'b0
) (
  input  logic [PHASE_W-1:0] idx,
  output logic [TAB_W-1:0]   val
);

  generate
    if (LOUD) begin : g_col
      // offset 80, amplitude 76 (about 2 dB above the row table)
      always_comb begin
        case (idx)
          4'd0:  val = 8'd80;
          4'd1:  val = 8'd109;
          4'd2:  val = 8'd134;
          4'd3:  val = 8'd150;
          4'd4:  val = 8'd156;
          4'd5:  val = 8'd150;
          4'd6:  val = 8'd134;
          4'd7:  val = 8'd109;
          4'd8:  val = 8'd80;
          4'd9:  val = 8'd51;
          4'd10: val = 8'd26;
          4'd11: val = 8'd10;
          4'd12: val = 8'd4;
          4'd13: val = 8'd10;
          4'd14: val = 8'd26;
          default: val = 8'd51;
        endcase
      end
    end else begin : g_row
      // offset 64, amplitude 60
      always_comb begin
        case (idx)
          4'd0:  val = 8'd64;
          4'd1:  val = 8'd87;
          4'd2:  val = 8'd106;
          4'd3:  val = 8'd119;
          4'd4:  val = 8'd124;
          4'd5:  val = 8'd119;
          4'd6:  val = 8'd106;
          4'd7:  val = 8'd87;
          4'd8:  val = 8'd64;
          4'd9:  val = 8'd41;
          4'd10: val = 8'd22;
          4'd11: val = 8'd9;
          4'd12: val = 8'd4;
          4'd13: val = 8'd9;
          4'd14: val = 8'd22;
          default: val = 8'd41;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/dtmf_tone_timer.sv
module dtmf_tone_timer
  import dtmf_gen_pkg::*;
#(
  parameter int TONE_CYC = 322160,
  parameter int GAP_CYC  = 322160
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        start,
  input  logic        key_held,
  output tone_state_e state,
  output logic        busy
);

  localparam int MAX_CYC = (TONE_CYC > GAP_CYC) ? TONE_CYC : GAP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] TONE_LAST = CNT_W'(TONE_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_TONE;
          cnt_q <= '0;
        end
        ST_TONE: begin
          if (cnt_q >= TONE_LAST && !key_held) begin
            state <= ST_GAP;
            cnt_q <= '0;
          end else if (cnt_q < TONE_LAST) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_GAP: begin
          if (cnt_q == GAP_LAST) begin
            state <= ST_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  p_min_tone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == ST_TONE && cnt_q < TONE_LAST) |=> state == ST_TONE);

  p_key_extends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == ST_TONE && key_held) |=> state == ST_TONE);

  p_full_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == ST_GAP && cnt_q < GAP_LAST) |=> state == ST_GAP);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> state == ST_IDLE);

endmodule

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen
  import dtmf_gen_pkg::*;
#(
  parameter int CLK_HZ       = 3579545,
  parameter int TONE_MS      = 90,
  parameter int GAP_MS       = 90,
  parameter int MIN_TONE_CYC = (CLK_HZ * TONE_MS + 999) / 1000,
  parameter int MIN_GAP_CYC  = (CLK_HZ * GAP_MS + 999) / 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tone_en,
  input  logic                key_held,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [3:0]          req_digit,
  input  logic [1:0]          req_mode,
  output logic                busy,
  output logic [SAMPLE_W-1:0] tone_sample
);

  localparam logic [DIV_W-1:0] ROW_RL [N_ROWS] = '{
    DIV_W'(reload_for(CLK_HZ, row_hz(0))), DIV_W'(reload_for(CLK_HZ, row_hz(1))),
    DIV_W'(reload_for(CLK_HZ, row_hz(2))), DIV_W'(reload_for(CLK_HZ, row_hz(3)))};
  localparam logic [DIV_W-1:0] COL_RL [N_COLS] = '{
    DIV_W'(reload_for(CLK_HZ, col_hz(0))), DIV_W'(reload_for(CLK_HZ, col_hz(1))),
    DIV_W'(reload_for(CLK_HZ, col_hz(2)))};

  tone_state_e state;
  key_pos_t    pos;
  logic        take;
  logic        start;
  logic        run;
  mix_e        mix_q;
  logic [1:0]             enab;
  logic [DIV_W-1:0]       rl   [2];
  logic [PHASE_W-1:0]     ph   [2];
  logic [TAB_W-1:0]       tv   [2];

  assign pos       = decode_key(req_digit);
  assign req_ready = tone_en && !busy;
  assign take      = req_valid && req_ready;
  assign start     = take && pos.ok;
  assign run       = (state == ST_TONE);

  assign rl[0] = ROW_RL[pos.row];
  assign rl[1] = (pos.col < 2'(N_COLS)) ? COL_RL[pos.col] : COL_RL[0];

  always_ff @(posedge clk) begin
    if (!rst_n)      mix_q <= MIX_DUAL;
    else if (start)  mix_q <= mix_e'(req_mode);
  end

  assign enab[0] = (mix_q != MIX_COL);
  assign enab[1] = (mix_q != MIX_ROW);

  generate
    for (genvar g = 0; g < 2; g++) begin : g_voice
      dtmf_phase_div #(.RL_W(DIV_W), .PH_W(PHASE_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .run    (run),
        .reload (rl[g]),
        .phase  (ph[g])
      );
      dtmf_sine_rom #(.LOUD(g == 1)) u_rom (
        .idx (ph[g]),
        .val (tv[g])
      );
    end
  endgenerate

  dtmf_tone_timer #(.TONE_CYC(MIN_TONE_CYC), .GAP_CYC(MIN_GAP_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (tone_en),
    .start    (start),
    .key_held (key_held),
    .state    (state),
    .busy     (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !tone_en || state != ST_TONE) begin
      tone_sample <= '0;
    end else begin
      tone_sample <= (enab[0] ? {1'b0, tv[0]} : '0) + (enab[1] ? {1'b0, tv[1]} : '0);
    end
  end

  p_ready_only_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

  p_taken_goes_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  p_bad_code_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !pos.ok) |=> !busy);

  p_pulse_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_en |=> tone_sample == '0);

  p_gap_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |=> tone_sample == '0);

endmodule

// File: tb/dtmf_tone_gen_bench.sv
module dtmf_tone_gen_bench;

  localparam int T = 2000;
  localparam int G = 600;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tone_en = 1'b1;
  logic       key_held = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_digit = '0;
  logic [1:0] req_mode = '0;
  logic       busy;
  logic [8:0] tone_sample;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk;

  dtmf_tone_gen #(.MIN_TONE_CYC(T), .MIN_GAP_CYC(G)) u_dtmf_tone_gen (
    .clk(clk), .rst_n(rst_n), .tone_en(tone_en), .key_held(key_held),
    .req_valid(req_valid), .req_ready(req_ready), .req_digit(req_digit),
    .req_mode(req_mode), .busy(busy), .tone_sample(tone_sample));

  // ---------------- reference model (from the requirements) ----------------
  function automatic int key_row(int d);   // R2
    if (d >= 1 && d <= 9) return (d - 1) / 3;
    return 3;
  endfunction

  function automatic int key_col(int d);   // R2
    if (d >= 1 && d <= 9) return (d - 1) % 3;
    if (d == 10) return 0;
    if (d == 0)  return 1;
    return 2;
  endfunction

  function automatic int ref_reload(real hz);   // R3
    return $rtoi(3579545.0 / (16.0 * hz) + 0.5);
  endfunction

  function automatic int row_reload(int r);
    real f [4] = '{699.0, 766.0, 848.0, 948.0};
    return ref_reload(f[r]);
  endfunction

  function automatic int col_reload(int c);
    real f [3] = '{1216.0, 1332.0, 1472.0};
    return ref_reload(f[c]);
  endfunction

  function automatic int sine_val(real off, real amp, int k);   // R4
    return $rtoi(off + amp * $sin(2.0 * 3.14159265358979 * k / 16.0) + 0.5);
  endfunction

  function automatic int exp_sample(int d, int mode, int t);    // R4 R5
    int s = 0;
    if (mode != 2) s += sine_val(64.0, 60.0, (t / row_reload(key_row(d))) % 16);
    if (mode != 1) s += sine_val(80.0, 76.0, (t / col_reload(key_col(d))) % 16);
    return s;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One full tone: K = edges after the taking edge with key_held high.
  task automatic play(int d, int mode, int K, bit hold_valid);
    int tone = (K + 1 > T) ? K + 1 : T;
    int busy_bad = -1, wave_bad = -1, wave_act = 0, wave_exp = 0, len = 0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready before request", int'(req_ready), 1);
    req_digit = 4'(d); req_mode = 2'(mode); req_valid = 1'b1; key_held = (K > 0);
    @(negedge clk);
    for (int m = 0; m <= tone + G; m++) begin
      if (!hold_valid || m == tone + G) req_valid = 1'b0;
      else req_digit = 4'((d + 1) % 12);
      if (busy !== (m < tone + G) && busy_bad < 0) busy_bad = m;
      if (tone_sample != 0) len++;
      begin
        int e = (m >= 1 && m <= tone) ? exp_sample(d, mode, m - 1) : 0;
        if (int'(tone_sample) != e && wave_bad < 0) begin
          wave_bad = m; wave_act = tone_sample; wave_exp = e;
        end
      end
      key_held = (m + 1 <= K);
      if (m < tone + G) @(negedge clk);
    end
    check(busy_bad < 0, "R7 R1 busy span (first bad cycle vs none)", busy_bad, -1);
    check(wave_bad < 0, "R3 R4 R5 sample waveform", wave_act, wave_exp);
    check(len == tone, "R6 tone length", len, tone);
  endtask

  task automatic bad_code(int d);   // R9
    @(negedge clk);
    req_digit = 4'(d); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b0, "R9 invalid code busy", int'(busy), 0);
    @(negedge clk);
    check(busy == 1'b0 && tone_sample == 0, "R9 invalid code silent", int'(tone_sample), 0);
  endtask

  task automatic abort_run();   // R8
    @(negedge clk);
    req_digit = 4'd5; req_mode = 2'd0; req_valid = 1'b1; key_held = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (300) @(negedge clk);
    check(tone_sample != 0, "R8 tone running before abort", int'(tone_sample), 1);
    tone_en = 1'b0;
    @(negedge clk);
    check(tone_sample == 0, "R8 abort silences", int'(tone_sample), 0);
    check(busy == 1'b0, "R8 abort clears busy", int'(busy), 0);
    check(req_ready == 1'b0, "R8 ready low in pulse mode", int'(req_ready), 0);
    req_valid = 1'b1; key_held = 1'b0;
    begin
      int bad = 0;
      repeat (50) begin
        @(negedge clk);
        if (busy || tone_sample != 0) bad++;
      end
      check(bad == 0, "R8 requests ignored in pulse mode", bad, 0);
    end
    req_valid = 1'b0;
    tone_en = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after tone mode returns", int'(req_ready), 1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R10 busy in reset", int'(busy), 0);
    check(tone_sample == 0, "R10 sample in reset", int'(tone_sample), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && tone_sample == 0, "R10 state after reset", int'(busy), 0);

    // every key, dual tone, shortest tone (R2 mapping over all codes)
    for (int d = 0; d < 12; d++) play(d, 0, 0, 1'b0);
    // single-tone test modes
    play(1, 1, 0, 1'b0);
    play(9, 2, 0, 1'b0);
    play(11, 3, 0, 1'b0);
    // R6 boundaries around the minimum tone
    play(4, 0, T - 1, 1'b0);
    play(4, 0, T, 1'b0);
    play(7, 0, T + 300, 1'b1);
    bad_code(12);
    bad_code(15);
    abort_run();

    for (int i = 0; i < 12; i++) begin
      int d = $urandom % 16;
      if (d >= 12) bad_code(d);
      else play(d, $urandom % 4, $urandom % (T + 400), 1'($urandom % 2));
    end
    finish_run();
  end

endmodule